// File: doc/BRIEF.md
# Multiplexed Grid Scan and Dimming Controller

This block drives a multiplexed vacuum-fluorescent display. A host fills a small segment memory that has one word per grid. It does this by loading a write pointer and then streaming words in; the pointer advances by one after every word. A scan engine visits the grids in turn. Each grid gets a fixed slot of 64 clocks. Inside its slot, the grid line and that grid's segment word are driven for a pulse at the start of the slot. A 4-bit brightness register sets the pulse length in steps of 4 clocks, so brightness is adjusted without changing the refresh rate.

A 4-bit span register holds the index of the last grid scanned, so 1 to 16 grids can be used. The span sets the scan period but never the pulse length. Changes to brightness and span are held back until the current scan period ends. A word written into the grid now on display is held back until the next slot starts. Neither kind of change can cut into a pulse. A separate 5-bit lamp latch drives discrete LEDs directly.

Top module: `vfd_scan_dimmer`

## Requirements
- R1: `addr_load` sets the write pointer to `addr_value`. Each `word_wr` stores `word_in` at the pointer and then advances the pointer by one. When both are high in one cycle, the word goes to `addr_value` and the pointer ends at `addr_value`+1. With neither high, the pointer holds.
- R2: The write pointer steps 15 to 0 whatever the span register holds.
- R3: The word at memory address k is shown on `grid_out[k]`, and bit i of the word drives `seg_out[i]`.
- R4: Each grid slot lasts 64 clocks. The scan period is 64 × (span + 1) clocks, and grids 0 through span are visited in ascending order.
- R5: A grid is active for the first 4 × duty clocks of its slot, as one unbroken pulse. A duty value of 0 keeps `grid_out` and `seg_out` at zero.
- R6: At most one bit of `grid_out` is high at a time. `seg_out` is zero whenever no grid is active.
- R7: Writes to the duty register (`duty_wr`) and the span register (`span_wr`) take effect at the start of the next scan period. Grids still to come in the current period keep the old settings.
- R8: A word written to the grid on display does not change `seg_out` during the current slot. It appears from that grid's next slot.
- R9: `led_load` copies `led_in` to `led_out`, where 1 means lit. Otherwise `led_out` holds.
- R10: Synchronous active-low reset clears the memory, the duty, span and lamp registers, and all counters. After reset the display is blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_load | input | 1 | Load the write pointer |
| addr_value | input | 4 | New write pointer value |
| word_wr | input | 1 | Store a segment word and advance the pointer |
| word_in | input | 16 | Segment word to store |
| duty_wr | input | 1 | Load the brightness register |
| duty_in | input | 4 | Pulse length in units of 4 clocks |
| span_wr | input | 1 | Load the span register |
| span_in | input | 4 | Index of the last grid scanned |
| led_load | input | 1 | Load the lamp latch |
| led_in | input | 5 | Lamp latch data |
| grid_out | output | 16 | One-hot grid enables |
| seg_out | output | 16 | Segment drive for the active grid |
| led_out | output | 5 | Lamp outputs, 1 = lit |

## Verification
The bench aims at the places where the scan logic most often goes wrong.

The write pointer is taken across 15 to 0 while only two grids are being scanned. A pointer that wrapped at the span would put those words on the wrong grids.

A brightness change is made in the middle of a scan period. If the design applied it at once, it would shorten the pulse of a later grid in the same period.

A segment word is rewritten while its own pulse is running. If the design did not hold the word back, the segment drive would change partway through the pulse.

Duty 0, a single-grid scan and the largest duty are covered as well. A design that got these wrong would let a grid flash at zero brightness, or would get the period or the pulse length wrong.

// File: rtl/vfd_pkg.sv
// Package: default dimensions shared by the scan controller and its checker.
// Assumes: the pulse at the largest duty fits inside one slot.
package vfd_pkg;
    localparam int unsigned VFD_GRIDS     = 16;
    localparam int unsigned VFD_SEG_W     = 16;
    localparam int unsigned VFD_SLOT_CLKS = 64;
    localparam int unsigned VFD_DUTY_STEP = 4;
    localparam int unsigned VFD_DUTY_W    = 4;
    localparam int unsigned VFD_LED_W     = 5;
endpackage

// File: rtl/vfd_seg_store.sv
// Module: segment word memory together with its self-advancing write pointer.
// Assumes: one write port; the read port is asynchronous, and the scan side
// registers what it reads. The pointer wraps at GRIDS-1 and ignores the span.
module vfd_seg_store #(
    parameter int GRIDS = 16,
    parameter int SEG_W = 16,
    localparam int ADDR_W = $clog2(GRIDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_value,
    input  logic              word_wr,
    input  logic [SEG_W-1:0]  word_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [SEG_W-1:0]  rd_word,
    output logic [ADDR_W-1:0] wr_ptr
);
    logic [SEG_W-1:0]  mem_q [GRIDS];
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] eff_next;

    // Address used this cycle: a pointer load wins over the stored pointer
    always_comb begin
        eff_addr = addr_load ? addr_value : wr_ptr;
        eff_next = (eff_addr == ADDR_W'(GRIDS - 1)) ? '0 : eff_addr + 1'b1;
    end

    // Write pointer: load, advance after a write, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (word_wr) begin
            wr_ptr <= eff_next;
        end else if (addr_load) begin
            wr_ptr <= addr_value;
        end
    end

    // One register per grid word, written when the address selects it
    for (genvar g = 0; g < GRIDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (word_wr && (eff_addr == ADDR_W'(g))) begin
                mem_q[g] <= word_in;
            end
        end
    end

    // Read port for the scan engine
    assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/vfd_scan_timer.sv
// Module: slot counter, digit counter and pulse window generator.
// Assumes: duty and span requests are static between writes. They are adopted
// only where a scan period ends, so a period always runs with one setting.
module vfd_scan_timer #(
    parameter int GRIDS     = 16,
    parameter int SLOT_CLKS = 64,
    parameter int DUTY_STEP = 4,
    parameter int DUTY_W    = 4,
    localparam int ADDR_W = $clog2(GRIDS),
    localparam int SLOT_W = $clog2(SLOT_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_req,
    input  logic [ADDR_W-1:0] span_req,
    output logic [SLOT_W-1:0] slot_pos,
    output logic [ADDR_W-1:0] cur_digit,
    output logic [ADDR_W-1:0] next_digit,
    output logic              slot_end,
    output logic              pulse_on,
    output logic [DUTY_W-1:0] duty_act,
    output logic [ADDR_W-1:0] span_act
);
    localparam int STEP_W = $clog2(DUTY_STEP + 1);
    localparam int CMP_W  = ((SLOT_W > DUTY_W + STEP_W) ? SLOT_W : DUTY_W + STEP_W) + 1;

    logic             period_end;
    logic [CMP_W-1:0] pulse_len;

    // Boundary decode and the grid that follows the current one
    always_comb begin
        slot_end   = (slot_pos == SLOT_W'(SLOT_CLKS - 1));
        period_end = slot_end && (cur_digit == span_act);
        next_digit = (cur_digit == span_act) ? '0 : cur_digit + 1'b1;
        pulse_len  = CMP_W'(duty_act) * CMP_W'(DUTY_STEP);
        pulse_on   = (CMP_W'(slot_pos) < pulse_len);
    end

    // Free-running position inside the slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_pos <= '0;
        end else if (slot_end) begin
            slot_pos <= '0;
        end else begin
            slot_pos <= slot_pos + 1'b1;
        end
    end

    // Grid index, advanced once per slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_digit <= '0;
        end else if (slot_end) begin
            cur_digit <= next_digit;
        end
    end

    // Settings in force, refreshed only at a period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act <= '0;
            span_act <= '0;
        end else if (period_end) begin
            duty_act <= duty_req;
            span_act <= span_req;
        end
    end
endmodule

// File: rtl/vfd_grid_drive.sv
// Module: latches the word for the coming slot and forms the grid and segment
// outputs from the pulse window.
// Assumes: rd_word is the word of next_digit and is stable at the slot boundary.
module vfd_grid_drive #(
    parameter int GRIDS = 16,
    parameter int SEG_W = 16,
    localparam int ADDR_W = $clog2(GRIDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_end,
    input  logic              pulse_on,
    input  logic [ADDR_W-1:0] cur_digit,
    input  logic [SEG_W-1:0]  rd_word,
    output logic [GRIDS-1:0]  grid_out,
    output logic [SEG_W-1:0]  seg_out
);
    logic [SEG_W-1:0] slot_word;

    // Word shown for the whole slot, captured as the slot begins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_word <= '0;
        end else if (slot_end) begin
            slot_word <= rd_word;
        end
    end

    // One enable per grid, on only inside the pulse window
    for (genvar g = 0; g < GRIDS; g++) begin : g_grid
        assign grid_out[g] = pulse_on && (cur_digit == ADDR_W'(g));
    end

    // Segment drive follows the pulse window
    assign seg_out = pulse_on ? slot_word : '0;
endmodule

// File: rtl/vfd_scan_dimmer.sv
// Module: top of the multiplexed display controller. It holds the host-facing
// registers and joins the word store, the scan timer and the output stage.
// Assumes: all inputs are synchronous to clk. Duty and span register writes
// are taken up by the timer at the next period boundary.
module vfd_scan_dimmer #(
    parameter int GRIDS     = vfd_pkg::VFD_GRIDS,
    parameter int SEG_W     = vfd_pkg::VFD_SEG_W,
    parameter int SLOT_CLKS = vfd_pkg::VFD_SLOT_CLKS,
    parameter int DUTY_STEP = vfd_pkg::VFD_DUTY_STEP,
    parameter int DUTY_W    = vfd_pkg::VFD_DUTY_W,
    parameter int LED_W     = vfd_pkg::VFD_LED_W,
    localparam int ADDR_W = $clog2(GRIDS),
    localparam int SLOT_W = $clog2(SLOT_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_value,
    input  logic              word_wr,
    input  logic [SEG_W-1:0]  word_in,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              span_wr,
    input  logic [ADDR_W-1:0] span_in,
    input  logic              led_load,
    input  logic [LED_W-1:0]  led_in,
    output logic [GRIDS-1:0]  grid_out,
    output logic [SEG_W-1:0]  seg_out,
    output logic [LED_W-1:0]  led_out
);
    logic [DUTY_W-1:0] duty_q;
    logic [ADDR_W-1:0] span_q;
    logic [ADDR_W-1:0] wr_ptr;
    logic [SEG_W-1:0]  rd_word;
    logic [SLOT_W-1:0] slot_pos;
    logic [ADDR_W-1:0] cur_digit;
    logic [ADDR_W-1:0] next_digit;
    logic              slot_end;
    logic              pulse_on;
    logic [DUTY_W-1:0] duty_act;
    logic [ADDR_W-1:0] span_act;

    // Host brightness request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (duty_wr) begin
            duty_q <= duty_in;
        end
    end

    // Host span request (index of the last grid)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
        end else if (span_wr) begin
            span_q <= span_in;
        end
    end

    // Lamp latch, positive logic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_out <= '0;
        end else if (led_load) begin
            led_out <= led_in;
        end
    end

    vfd_seg_store #(.GRIDS(GRIDS), .SEG_W(SEG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_load  (addr_load),
        .addr_value (addr_value),
        .word_wr    (word_wr),
        .word_in    (word_in),
        .rd_addr    (next_digit),
        .rd_word    (rd_word),
        .wr_ptr     (wr_ptr)
    );

    vfd_scan_timer #(
        .GRIDS(GRIDS), .SLOT_CLKS(SLOT_CLKS), .DUTY_STEP(DUTY_STEP), .DUTY_W(DUTY_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .duty_req   (duty_q),
        .span_req   (span_q),
        .slot_pos   (slot_pos),
        .cur_digit  (cur_digit),
        .next_digit (next_digit),
        .slot_end   (slot_end),
        .pulse_on   (pulse_on),
        .duty_act   (duty_act),
        .span_act   (span_act)
    );

    vfd_grid_drive #(.GRIDS(GRIDS), .SEG_W(SEG_W)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_end  (slot_end),
        .pulse_on  (pulse_on),
        .cur_digit (cur_digit),
        .rd_word   (rd_word),
        .grid_out  (grid_out),
        .seg_out   (seg_out)
    );
endmodule

// File: rtl/vfd_scan_dimmer_chk.sv
// Module: property checker for the scan controller, bound to the top module.
// Assumes: it only observes; it drives nothing back into the design.
module vfd_scan_dimmer_chk #(
    parameter int GRIDS     = 16,
    parameter int SEG_W     = 16,
    parameter int SLOT_CLKS = 64,
    parameter int DUTY_W    = 4,
    parameter int LED_W     = 5,
    localparam int ADDR_W = $clog2(GRIDS),
    localparam int SLOT_W = $clog2(SLOT_CLKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_load,
    input logic [ADDR_W-1:0] addr_value,
    input logic              word_wr,
    input logic              led_load,
    input logic [LED_W-1:0]  led_in,
    input logic [LED_W-1:0]  led_out,
    input logic [GRIDS-1:0]  grid_out,
    input logic [SEG_W-1:0]  seg_out,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [ADDR_W-1:0] cur_digit,
    input logic [ADDR_W-1:0] span_act,
    input logic [SLOT_W-1:0] slot_pos,
    input logic [DUTY_W-1:0] duty_act
);
    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) word_wr && !addr_load |=> wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)); // R2
    AST_WPTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) addr_load && !word_wr |=> wr_ptr == $past(addr_value)); // R1
    AST_WPTR_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n) addr_load && word_wr |=> wr_ptr == ADDR_W'($past(addr_value) + 1'b1)); // R1
    AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !addr_load && !word_wr |=> $stable(wr_ptr)); // R1
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) slot_pos == SLOT_W'(SLOT_CLKS - 1) |=> slot_pos == '0); // R4
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cur_digit <= span_act); // R4
    AST_ZERO_DUTY_BLANK: assert property (@(posedge clk) disable iff (!rst_n) duty_act == '0 |-> grid_out == '0); // R5
    AST_PULSE_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n) (grid_out != '0) && (slot_pos != '0) |-> $past(grid_out) == grid_out); // R5
    AST_GRID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grid_out)); // R6
    AST_SEG_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) grid_out == '0 |-> seg_out == '0); // R6
    AST_SEG_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (grid_out != '0) && ($past(grid_out) == grid_out) |-> $stable(seg_out)); // R8
    AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rst_n) led_load |=> led_out == $past(led_in)); // R9
    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !led_load |=> $stable(led_out)); // R9
endmodule

bind vfd_scan_dimmer vfd_scan_dimmer_chk #(
    .GRIDS(GRIDS), .SEG_W(SEG_W), .SLOT_CLKS(SLOT_CLKS), .DUTY_W(DUTY_W), .LED_W(LED_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_load  (addr_load),
    .addr_value (addr_value),
    .word_wr    (word_wr),
    .led_load   (led_load),
    .led_in     (led_in),
    .led_out    (led_out),
    .grid_out   (grid_out),
    .seg_out    (seg_out),
    .wr_ptr     (wr_ptr),
    .cur_digit  (cur_digit),
    .span_act   (span_act),
    .slot_pos   (slot_pos),
    .duty_act   (duty_act)
);

// File: tb/vfd_scan_dimmer_test.sv
module vfd_scan_dimmer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [3:0]  addr_value = '0;
    logic        word_wr = 1'b0;
    logic [15:0] word_in = '0;
    logic        duty_wr = 1'b0;
    logic [3:0]  duty_in = '0;
    logic        span_wr = 1'b0;
    logic [3:0]  span_in = '0;
    logic        led_load = 1'b0;
    logic [4:0]  led_in = '0;
    logic [15:0] grid_out;
    logic [15:0] seg_out;
    logic [4:0]  led_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] exp_ram [16];
    int mptr = 0;

    // duty, span, expected width, expected period
    localparam logic [31:0] VEC [6] = '{
        {4'd1,  4'd15, 8'd4,  16'd1024},
        {4'd15, 4'd15, 8'd60, 16'd1024},
        {4'd8,  4'd3,  8'd32, 16'd256},
        {4'd3,  4'd0,  8'd12, 16'd64},
        {4'd15, 4'd0,  8'd60, 16'd64},
        {4'd10, 4'd6,  8'd40, 16'd448}
    };

    vfd_scan_dimmer uut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_value(addr_value),
        .word_wr(word_wr), .word_in(word_in), .duty_wr(duty_wr), .duty_in(duty_in),
        .span_wr(span_wr), .span_in(span_in), .led_load(led_load), .led_in(led_in),
        .grid_out(grid_out), .seg_out(seg_out), .led_out(led_out)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_duty(input logic [3:0] v);
        duty_in = v; duty_wr = 1'b1; tick(); duty_wr = 1'b0;
    endtask

    task automatic set_span(input logic [3:0] v);
        span_in = v; span_wr = 1'b1; tick(); span_wr = 1'b0;
    endtask

    task automatic load_ptr(input int v);
        addr_value = 4'(v); addr_load = 1'b1; tick(); addr_load = 1'b0;
        mptr = v;
    endtask

    task automatic put_word(input logic [15:0] w);
        word_in = w; word_wr = 1'b1; tick(); word_wr = 1'b0;
        exp_ram[mptr] = w;
        mptr = (mptr + 1) % 16;
    endtask

    function automatic logic [15:0] pattern(input int k);
        return {4'(k), ~4'(k), 4'(k + 3), 4'(k) ^ 4'h9};
    endfunction

    // Wait until grid bit b goes from 0 to 1; found=0 if the limit expires
    task automatic wait_rise(input int b, input int limit, output bit found);
        logic prev;
        found = 1'b0;
        prev = grid_out[b];
        for (int i = 0; i < limit; i++) begin
            tick();
            if (!prev && grid_out[b]) begin
                found = 1'b1;
                break;
            end
            prev = grid_out[b];
        end
    endtask

    // Count cycles grid bit b stays high, starting on a rising sample
    task automatic high_len(input int b, output int w);
        w = 0;
        while (grid_out[b]) begin
            w++;
            tick();
        end
    endtask

    // From a rise of grid 0: pulse width, period, grids seen, segment mismatches
    task automatic measure(output int width, output int period,
                           output logic [15:0] mask, output int segerr);
        bit found, fell;
        wait_rise(0, 5000, found);
        width = 0; period = 0; mask = '0; segerr = 0; fell = 1'b0;
        if (!found) return;
        for (int t = 0; t < 5000; t++) begin
            mask |= grid_out;
            if ($countones(grid_out) > 1) segerr++;
            if (grid_out == '0) begin
                if (seg_out != '0) segerr++;
            end else begin
                for (int i = 0; i < 16; i++)
                    if (grid_out[i] && seg_out != exp_ram[i]) segerr++;
            end
            if (grid_out[0] && !fell) width++;
            else fell = 1'b1;
            period++;
            tick();
            if (grid_out[0] && fell) break;
        end
    endtask

    initial begin
        int w, p, se;
        logic [15:0] m;
        bit found;
        logic [15:0] old_w;
        for (int i = 0; i < 16; i++) exp_ram[i] = '0;

        // Reset state (R10)
        repeat (3) tick();
        chk(grid_out == '0 && seg_out == '0, "R10", "outputs in reset", {grid_out, seg_out}, 0);
        chk(led_out == '0, "R10", "lamps in reset", led_out, 0);
        rst_n = 1'b1;
        found = 1'b0;
        for (int i = 0; i < 200; i++) begin
            tick();
            if (grid_out != '0) found = 1'b1;
        end
        chk(!found, "R10", "blank after reset", found, 0);

        // Memory cleared by reset: all grids lit with empty segments (R10)
        set_duty(4'd15);
        set_span(4'd15);
        wait_rise(0, 5000, found);
        measure(w, p, m, se);
        chk(se == 0, "R10", "segment words after reset", se, 0);
        chk(m == 16'hFFFF, "R4", "grids visited at span 15", m, 16'hFFFF);

        // Fill memory with span set to 2 grids, then wrap the pointer (R1, R2)
        set_span(4'd1);
        load_ptr(0);
        for (int k = 0; k < 16; k++) put_word(pattern(k));
        load_ptr(14);
        for (int k = 0; k < 4; k++) put_word(16'hC000 | 16'(k));
        // Load and write together: word lands at the loaded address (R1)
        addr_value = 4'd7; addr_load = 1'b1; word_in = 16'h7A7A; word_wr = 1'b1;
        tick();
        addr_load = 1'b0; word_wr = 1'b0;
        exp_ram[7] = 16'h7A7A; mptr = 8;
        put_word(16'h8B8B);

        // Table of brightness and span settings (R3, R4, R5, R6)
        for (int v = 0; v < 6; v++) begin
            logic [3:0] dv, sv;
            int ew, ep;
            logic [15:0] em;
            dv = VEC[v][31:28]; sv = VEC[v][27:24];
            ew = int'(VEC[v][23:16]); ep = int'(VEC[v][15:0]);
            em = 16'((32'd1 << (int'(sv) + 1)) - 1);
            set_duty(dv);
            set_span(sv);
            wait_rise(0, 5000, found);
            measure(w, p, m, se);
            chk(w == ew, "R5", $sformatf("pulse width vec %0d", v), w, ew);
            chk(p == ep, "R4", $sformatf("scan period vec %0d", v), p, ep);
            chk(m == em, "R4", $sformatf("grids visited vec %0d", v), m, em);
            chk(se == 0, "R3", $sformatf("segments and one-hot (R6) vec %0d", v), se, 0);
        end

        // Pointer wrap landed on 14,15,0,1 and the load-write on 7,8 (R2)
        set_span(4'd15);
        set_duty(4'd15);
        wait_rise(0, 5000, found);
        measure(w, p, m, se);
        chk(se == 0 && exp_ram[0] == 16'hC002 && exp_ram[15] == 16'hC001,
            "R2", "words after pointer wrap", se, 0);

        // Duty 0 blanks everything (R5)
        set_duty(4'd0);
        repeat (1100) tick();
        found = 1'b0;
        for (int i = 0; i < 1100; i++) begin
            if (grid_out != '0 || seg_out != '0) found = 1'b1;
            tick();
        end
        chk(!found, "R5", "duty 0 blank", found, 0);

        // Duty change mid-period waits for the period end (R7)
        set_duty(4'd15);
        wait_rise(0, 5000, found);
        wait_rise(0, 5000, found);
        duty_in = 4'd2; duty_wr = 1'b1; tick(); duty_wr = 1'b0;
        wait_rise(1, 200, found);
        high_len(1, w);
        chk(w == 60, "R7", "later grid keeps old duty", w, 60);
        wait_rise(0, 2000, found);
        high_len(0, w);
        chk(w == 8, "R7", "new duty next period", w, 8);

        // Span change mid-period waits for the period end (R7)
        wait_rise(0, 2000, found);
        span_in = 4'd3; span_wr = 1'b1; tick(); span_wr = 1'b0;
        wait_rise(15, 1100, found);
        chk(found, "R7", "grid 15 still scanned this period", found, 1);
        measure(w, p, m, se);
        chk(p == 256, "R7", "new span period", p, 256);

        // Write to the grid on display shows from its next slot (R8)
        set_span(4'd0);
        set_duty(4'd15);
        wait_rise(0, 5000, found);
        wait_rise(0, 5000, found);
        old_w = exp_ram[0];
        addr_value = 4'd0; addr_load = 1'b1; word_in = 16'h5EED; word_wr = 1'b1;
        tick();
        addr_load = 1'b0; word_wr = 1'b0;
        se = 0;
        while (grid_out[0]) begin
            if (seg_out != old_w) se++;
            tick();
        end
        chk(se == 0, "R8", "segments unchanged mid pulse", se, 0);
        wait_rise(0, 200, found);
        chk(seg_out == 16'h5EED, "R8", "new word next slot", seg_out, 16'h5EED);

        // Lamp latch (R9)
        led_in = 5'b10110; led_load = 1'b1; tick(); led_load = 1'b0;
        chk(led_out == 5'b10110, "R9", "lamp load", led_out, 5'b10110);
        led_in = 5'b01001; repeat (3) tick();
        chk(led_out == 5'b10110, "R9", "lamp hold without strobe", led_out, 5'b10110);

        // Reset mid-run clears everything (R10)
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk(led_out == '0 && grid_out == '0 && seg_out == '0, "R10", "reset mid-run",
            {led_out, grid_out, seg_out}, 0);
        found = 1'b0;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (grid_out != '0) found = 1'b1;
        end
        chk(!found, "R10", "duty cleared by reset", found, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule